// File: doc/BRIEF.md
# Maskable Edge-Sensed Priority Interrupt Controller

This block gathers interrupt requests from twelve external pins and twenty-one on-chip peripheral level requests. It presents the single most urgent pending request to the processor as a registered accept strobe with a vector index. The external pins fall into two groups: four high-priority lines and eight general lines. Each pin is first brought into the clock domain, then edge-detected on the polarity chosen for that pin. A request flag latches on that edge and stays set until it is cleared. The peripheral requests are plain levels and are never latched.

A global mask input stops the accept strobe, but the flags keep latching, so no edge is lost while the processor runs with interrupts off. From reset the strobe is also held off until the processor signals that it has retired its first instruction. That instruction can therefore always set up the stack before any interrupt is taken. Stacking and vector fetch are left to the processor.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `irq_take_o` is 0 and every bit of `flag_o` is 0 until a qualifying edge arrives.
- R2: External line i (bits 0 to 3 are the high-priority group, bits 4 to 11 the general group) passes through two synchronizer flops. When `edge_rise_i[i]`=1 a 0-to-1 transition sets `flag_o[i]`; when it is 0 a 1-to-0 transition sets it. The flag rises at the third rising clock edge after the input first holds its new level at a rising clock edge, counting that edge as the first.
- R3: A transition of the polarity not selected by `edge_rise_i[i]` leaves `flag_o[i]` unchanged.
- R4: The request pending at the lowest index wins. External flag i has index i. Peripheral request j has index 12+j. `irq_vec_o` carries the winner's index.
- R5: `irq_take_o` and `irq_vec_o` are registered. `irq_take_o` is 1 at the clock edge after one at which a request was pending, `gmask_i` was 0 and the post-reset hold was lifted.
- R6: While `gmask_i` is 1, `irq_take_o` stays 0, and external flags still latch on their selected edges.
- R7: After reset the hold is lifted by the clock edge that samples `first_done_i`=1. `irq_take_o` can then be 1 no earlier than the following edge. The hold does not return until the next reset.
- R8: `ack_i`=1 with `ack_vec_i`=i (i below 12) clears `flag_o[i]` at the next edge. An acknowledge naming a peripheral index changes no flag.
- R9: `sw_clr_i[i]`=1 clears `flag_o[i]` at the next edge.
- R10: If a selected edge on line i reaches the flag in the same cycle as a clear by acknowledge or `sw_clr_i`, the flag is 1 afterwards.
- R11: Peripheral requests are not latched: once `peri_req_i[j]` drops, `irq_take_o` for index 12+j ends at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_line_i | input | 12 | External request pins, asynchronous |
| edge_rise_i | input | 12 | Per pin: 1 selects the rising edge, 0 the falling edge |
| peri_req_i | input | 21 | Peripheral level requests |
| gmask_i | input | 1 | Global mask: 1 blocks acceptance |
| first_done_i | input | 1 | Pulse when the first instruction after reset has retired |
| ack_i | input | 1 | Processor acknowledge |
| ack_vec_i | input | 6 | Vector index being acknowledged |
| sw_clr_i | input | 12 | Software clear, one bit per external flag |
| flag_o | output | 12 | External request flags |
| irq_take_o | output | 1 | Registered accept strobe |
| irq_vec_o | output | 6 | Vector index of the accepted request |

## Verification
The hardest case to reach is R10, where a fresh edge and a clear meet at the flag register in the same cycle. Because of the synchronizer, the bench must time the clear two cycles after it drives the pin. It keeps the flag already set beforehand, so a lost edge would show up as a cleared flag. The post-reset hold is exercised with requests already waiting before `first_done_i` is pulsed. Masked latching is covered by raising pins while `gmask_i` is high and then lowering the mask.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic edge_o,
  output logic flag_o
);
  logic sy1_q, sy2_q, old_q, flag_q;
  logic flag_d;
  edge_pol_e pol;

  assign pol = edge_pol_e'(pol_i);

  always_comb begin
    if (pol == POL_RISE) edge_o = sy2_q & ~old_q;
    else                 edge_o = ~sy2_q & old_q;
    flag_d = edge_o | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q  <= 1'b0;
      sy2_q  <= 1'b0;
      old_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sy1_q  <= line_i;
      sy2_q  <= sy1_q;
      old_q  <= sy2_q;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int N  = 33,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        hit_o = 1'b1;
        idx_o = IW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter  int N_IRQ  = 4,
  parameter  int N_INT  = 8,
  parameter  int N_PERI = 21,
  localparam int N_EXT  = N_IRQ + N_INT,
  localparam int N_SRC  = N_EXT + N_PERI,
  localparam int VW     = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_line_i,
  input  logic [N_EXT-1:0]  edge_rise_i,
  input  logic [N_PERI-1:0] peri_req_i,
  input  logic              gmask_i,
  input  logic              first_done_i,
  input  logic              ack_i,
  input  logic [VW-1:0]     ack_vec_i,
  input  logic [N_EXT-1:0]  sw_clr_i,
  output logic [N_EXT-1:0]  flag_o,
  output logic              irq_take_o,
  output logic [VW-1:0]     irq_vec_o
);
  logic [N_EXT-1:0] ext_clr;
  logic [N_EXT-1:0] ext_edge;
  logic [N_EXT-1:0] ext_flag;
  logic [N_SRC-1:0] pend_w;
  logic             hit;
  logic [VW-1:0]    win_idx;
  logic             arm_q, arm_d;
  logic             take_q, take_d;
  logic [VW-1:0]    vec_q;
  logic             vec_en;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    assign ext_clr[i] = sw_clr_i[i] | (ack_i && (ack_vec_i == VW'(i)));

    irqc_edge_latch u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (ext_line_i[i]),
      .pol_i  (edge_rise_i[i]),
      .clr_i  (ext_clr[i]),
      .edge_o (ext_edge[i]),
      .flag_o (ext_flag[i])
    );
  end

  assign pend_w = {peri_req_i, ext_flag};

  irqc_prio_enc #(.N(N_SRC), .IW(VW)) u_enc (
    .req_i (pend_w),
    .hit_o (hit),
    .idx_o (win_idx)
  );

  always_comb begin
    arm_d  = arm_q | first_done_i;
    take_d = hit & ~gmask_i & arm_q;
    vec_en = take_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      arm_q  <= arm_d;
      take_q <= take_d;
      if (vec_en) vec_q <= win_idx;
    end
  end

  assign flag_o     = ext_flag;
  assign irq_take_o = take_q;
  assign irq_vec_o  = vec_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N_EXT = 12,
  parameter int N_SRC = 33,
  parameter int VW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gmask_i,
  input logic [N_EXT-1:0] sw_clr_i,
  input logic [N_EXT-1:0] ext_edge,
  input logic [N_EXT-1:0] ext_flag,
  input logic [N_SRC-1:0] pend_w,
  input logic             arm_q,
  input logic             irq_take_o,
  input logic [VW-1:0]    irq_vec_o
);
  a_r6_mask_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> !$past(gmask_i));

  a_r7_hold_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> $past(arm_q));

  a_r7_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> arm_q);

  a_r4_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> (irq_vec_o < VW'(N_SRC)));

  a_r4_no_lower_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> (($past(pend_w) & ~({N_SRC{1'b1}} << irq_vec_o)) == '0));

  a_r5_take_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> $past(pend_w) != '0);

  for (genvar i = 0; i < N_EXT; i++) begin : g_bit
    a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ext_edge[i] |=> ext_flag[i]);

    a_r9_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_i[i] && !ext_edge[i]) |=> !ext_flag[i]);
  end
endmodule

bind irq_prio_ctrl irqc_chk #(.N_EXT(N_EXT), .N_SRC(N_SRC), .VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gmask_i    (gmask_i),
  .sw_clr_i   (sw_clr_i),
  .ext_edge   (ext_edge),
  .ext_flag   (ext_flag),
  .pend_w     (pend_w),
  .arm_q      (arm_q),
  .irq_take_o (irq_take_o),
  .irq_vec_o  (irq_vec_o)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] ext_line_i, edge_rise_i, sw_clr_i;
  logic [20:0] peri_req_i;
  logic        gmask_i, first_done_i, ack_i;
  logic [5:0]  ack_vec_i;
  logic [11:0] flag_o;
  logic        irq_take_o;
  logic [5:0]  irq_vec_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (.*);

  // behavioural reference: sample history queue, flag list, hold bit
  logic [11:0] hist[$];
  logic [11:0] m_flag;
  bit          m_arm, m_take;
  int          m_vec;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hist = '{12'h0, 12'h0, 12'h0};
      m_flag = '0; m_arm = 0; m_take = 0; m_vec = 0;
    end else begin
      logic [11:0] nf;
      logic [32:0] pend;
      int win;
      pend = {peri_req_i, m_flag};
      win = -1;
      for (int k = 32; k >= 0; k--) if (pend[k]) win = k;
      m_take = (win >= 0) && !gmask_i && m_arm;
      if (m_take) m_vec = win;
      for (int i = 0; i < 12; i++) begin
        bit ed, clr;
        ed  = edge_rise_i[i] ? (hist[1][i] && !hist[2][i]) : (!hist[1][i] && hist[2][i]);
        clr = sw_clr_i[i] || (ack_i && ack_vec_i == 6'(i));
        nf[i] = ed || (m_flag[i] && !clr);
      end
      m_flag = nf;
      m_arm = m_arm || first_done_i;
      hist.push_front(ext_line_i);
      hist.pop_back();
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (irq_take_o !== m_take || flag_o !== m_flag || (m_take && irq_vec_o !== 6'(m_vec))) begin
      errors++;
      $display("FAIL R2 R5 model cycle %0d: take %0b flag %h vec %0d, expected %0b %h %0d",
               cyc, irq_take_o, flag_o, irq_vec_o, m_take, m_flag, m_vec);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait (cyc > 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; ext_line_i = '0; edge_rise_i = 12'hF7F; sw_clr_i = '0;
    peri_req_i = '0; gmask_i = 0; first_done_i = 0; ack_i = 0; ack_vec_i = '0;
    wt(3);
    chk("R1 take in reset", irq_take_o, 0);
    chk("R1 flags in reset", flag_o, 0);
    rst_n = 1;
    wt(4);
    chk("R1 flags after reset", flag_o, 0);
    // requests wait before the first instruction retires
    peri_req_i[5] = 1; ext_line_i[2] = 1;
    wt(2);
    chk("R2 flag not yet", flag_o[2], 0);
    wt(1);
    chk("R2 flag on third edge", flag_o[2], 1);
    wt(5);
    chk("R7 held before first instruction", irq_take_o, 0);
    first_done_i = 1; wt(1); first_done_i = 0;
    chk("R7 not on arming edge", irq_take_o, 0);
    wt(1);
    chk("R7 take after hold lifted", irq_take_o, 1);
    chk("R4 ext line 2 beats peripheral 5", irq_vec_o, 2);
    ack_i = 1; ack_vec_i = 6'd2; wt(1); ack_i = 0;
    chk("R8 ack clears flag", flag_o[2], 0);
    wt(1);
    chk("R4 peripheral 5 index", irq_vec_o, 17);
    peri_req_i[5] = 0; wt(1);
    chk("R11 level removed ends take", irq_take_o, 0);
    // falling polarity on line 7
    ext_line_i[7] = 1; wt(5);
    chk("R3 wrong polarity ignored", flag_o[7], 0);
    ext_line_i[7] = 0; wt(4);
    chk("R2 falling edge sets flag", flag_o[7], 1);
    sw_clr_i[7] = 1; wt(1); sw_clr_i[7] = 0;
    chk("R9 software clear", flag_o[7], 0);
    // masked latching
    gmask_i = 1; ext_line_i[0] = 1; wt(6);
    chk("R6 flag latches while masked", flag_o[0], 1);
    chk("R6 no take while masked", irq_take_o, 0);
    gmask_i = 0;
    chk("R5 take registered", irq_take_o, 0);
    wt(1);
    chk("R5 take one edge after unmask", irq_take_o, 1);
    chk("R4 line 0 highest", irq_vec_o, 0);
    ack_i = 1; ack_vec_i = 6'd20; wt(1); ack_i = 0;
    chk("R8 peripheral ack leaves flag", flag_o[0], 1);
    ext_line_i[0] = 0; sw_clr_i[0] = 1; wt(1); sw_clr_i[0] = 0;
    chk("R9 clear line 0", flag_o[0], 0);
    wt(4);
    // edge meets clear on line 3 with flag already set
    ext_line_i[3] = 1; wt(4);
    chk("R2 line 3 set", flag_o[3], 1);
    ext_line_i[3] = 0; wt(4);
    ext_line_i[3] = 1; wt(2);
    sw_clr_i[3] = 1; wt(1); sw_clr_i[3] = 0;
    chk("R10 edge wins over clear", flag_o[3], 1);
    ack_i = 1; ack_vec_i = 6'd3; wt(1); ack_i = 0;
    chk("R8 ack line 3", flag_o[3], 0);
    // several peripherals, lowest wins
    peri_req_i = 21'h100410; wt(3);
    chk("R4 lowest peripheral", irq_vec_o, 16);
    peri_req_i = '0; wt(3);
    chk("R11 all idle", irq_take_o, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule